// File: doc/BRIEF.md
# Segmented Up-Counter with Early Terminal Flag

A wide free-running up-counter whose bits are kept in short segments rather than one long adder. The lowest segment steps on every enabled cycle. Each higher segment steps only when a registered carry-enable says that every bit below it is one. That carry-enable is worked out one count early, while the lower bits are one step short of all ones. The register-to-register logic is therefore one narrow segment increment plus a small AND, whatever the total width. Seen from the outside, the count still behaves exactly like a plain binary counter.

The block also compares the count with a programmable target and produces a single registered bit that is high in the cycles where the count equals the target. The compare is made against the value the count is about to take, that is the target minus one while counting. A downstream state machine can then use the bit directly as its transition condition, without needing any wide decode of its own. With the default parameters the counter is 32 bits wide, split into a 4-bit lowest segment, three 8-bit segments and a 4-bit top segment.

Top module: `seg_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes zero and `at_target` becomes 0. All internal carry-enables are cleared, so counting afterwards starts cleanly from zero. In the first cycle after reset, `at_target` reads 0 whatever the target.
- R2: Each rising edge with `en` high and `rst` low advances `count` by exactly one, modulo 2^CNT_W, so it matches a reference binary counter every cycle.
- R3: The lowest LO_W bits step on every enabled edge. A higher segment steps only on an enabled edge at which all bits below it are one, and it moves in the same edge at which the bits below wrap to zero.
- R4: From the all-ones value, one enabled edge gives zero and the next gives one, with no skipped or repeated value.
- R5: A rising edge with `en` low leaves `count` unchanged, and with `target` steady it leaves `at_target` unchanged.
- R6: From the second cycle after reset, with `target` held steady, `at_target` is 1 exactly in the cycles where `count` equals `target`. This includes a target reached by counting and a target the count is already sitting on.
- R7: R6 holds for the edge targets: 0 (reached just after reset and again after each wrap), 1, and the all-ones value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| target | input | CNT_W | Value at which the flag is raised |
| count | output | CNT_W | Current count |
| at_target | output | 1 | Registered flag, high while count equals target |

## Verification
The bench builds the block with a 10-bit count: a 2-bit lowest segment, two 3-bit middle segments and a short 2-bit top segment. At that size a full wrap is reachable in about a thousand cycles, so every segment roll, the uneven top segment and the all-ones to zero step are compared against an arithmetic model cycle by cycle. Each of several targets (0, 1, all ones, a segment boundary and two interior values) gets its own reset. Each run starts with enable held low and then uses a gapped enable pattern, so the flag is seen being reached by counting, held while the count sits still, and re-raised after the wrap.

// File: rtl/seg_cnt_pkg.sv
package seg_cnt_pkg;

    // number of segments: one low segment plus as many upper ones as needed
    function automatic int seg_num(input int cw, input int lw, input int sw);
        return 1 + (cw - lw + sw - 1) / sw;
    endfunction

    // bit position of segment i inside the full count
    function automatic int seg_lsb(input int i, input int lw, input int sw);
        return (i == 0) ? 0 : lw + (i - 1) * sw;
    endfunction

    // width of segment i; only the topmost one may be narrower than sw
    function automatic int seg_wid(input int i, input int cw, input int lw, input int sw);
        int rest;
        if (i == 0) return lw;
        rest = cw - seg_lsb(i, lw, sw);
        return (rest < sw) ? rest : sw;
    endfunction

endpackage

// File: rtl/cnt_segment.sv
module cnt_segment #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] val_q
);

    logic [W-1:0] val_d;

    always_comb begin
        val_d = val_q;
        if (step) begin
            val_d = val_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    AST_SEG_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> val_q == $past(val_q) + W'(1)); // R3
    AST_SEG_IDLE: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(val_q)); // R3

endmodule

// File: rtl/seg_carry.sv
module seg_carry
    import seg_cnt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LO_W  = 4,
    parameter int SEG_W = 8
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic                                           en,
    input  logic [seg_lsb(seg_num(CNT_W, LO_W, SEG_W) - 1, LO_W, SEG_W)-1:0] low_cnt,
    output logic [seg_num(CNT_W, LO_W, SEG_W)-2:0]         carry_q
);

    localparam int NSEG = seg_num(CNT_W, LO_W, SEG_W);
    localparam int NC   = NSEG - 1;
    localparam logic [LO_W-1:0] LO_NEAR = {LO_W{1'b1}} - 1'b1;

    typedef struct packed {
        logic [NC-1:0] carry;
    } carry_st_t;

    carry_st_t cur_q, nxt_d;
    logic      run;

    // carry k enables segment k+1: set one count before the bits below wrap
    always_comb begin
        nxt_d = cur_q;
        run = (low_cnt[LO_W-1:0] == LO_NEAR);
        nxt_d.carry[0] = en ? run : cur_q.carry[0];
        for (int k = 1; k < NC; k++) begin
            run = run & (&low_cnt[LO_W + (k - 1) * SEG_W +: SEG_W]);
            nxt_d.carry[k] = en ? run : cur_q.carry[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign carry_q = cur_q.carry;

    for (genvar k = 0; k < NC; k++) begin : g_chk
        localparam int TOP = LO_W + k * SEG_W;
        AST_CARRY_ALIGN: assert property (@(posedge clk) disable iff (rst)
            carry_q[k] == (&low_cnt[TOP-1:0])); // R3
    end

endmodule

// File: rtl/term_detect.sv
module term_detect #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] target,
    output logic             flag_q
);

    typedef struct packed {
        logic flag;
    } term_st_t;

    term_st_t cur_q, nxt_d;

    // compare against the value the count will hold after this edge
    always_comb begin
        nxt_d = cur_q;
        if (en) begin
            nxt_d.flag = (cnt == target - 1'b1);
        end else begin
            nxt_d.flag = (cnt == target);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign flag_q = cur_q.flag;

    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
        !rst |=> flag_q == (cnt == $past(target))); // R6

endmodule

// File: rtl/seg_counter.sv
module seg_counter
    import seg_cnt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LO_W  = 4,
    parameter int SEG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] target,
    output logic [CNT_W-1:0] count,
    output logic             at_target
);

    localparam int NSEG  = seg_num(CNT_W, LO_W, SEG_W);
    localparam int NC    = NSEG - 1;
    localparam int LOW_W = seg_lsb(NSEG - 1, LO_W, SEG_W);

    logic [NC-1:0] carry;

    seg_carry #(
        .CNT_W (CNT_W),
        .LO_W  (LO_W),
        .SEG_W (SEG_W)
    ) u_carry (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .low_cnt (count[LOW_W-1:0]),
        .carry_q (carry)
    );

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        localparam int LSB = seg_lsb(i, LO_W, SEG_W);
        localparam int WID = seg_wid(i, CNT_W, LO_W, SEG_W);
        logic step;
        logic [WID-1:0] val;
        if (i == 0) begin : g_low
            assign step = en;
        end else begin : g_up
            assign step = en & carry[i-1];
        end
        cnt_segment #(
            .W (WID)
        ) u_seg (
            .clk   (clk),
            .rst   (rst),
            .step  (step),
            .val_q (val)
        );
        assign count[LSB +: WID] = val;
    end

    term_detect #(
        .CNT_W (CNT_W)
    ) u_term (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .cnt    (count),
        .target (target),
        .flag_q (at_target)
    );

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        en |=> count == $past(count) + 1'b1); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count)); // R5

endmodule

// File: tb/sim_seg_counter.sv
module sim_seg_counter;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = 10;
    localparam int LW = 2;
    localparam int SW = 3;
    localparam logic [CW-1:0] MAXV = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic [CW-1:0] target = '0;
    logic [CW-1:0] count;
    logic          at_target;

    logic [CW-1:0] ref_cnt = '0;
    logic          ref_flag = 1'b0;
    logic          was_rst = 1'b1;
    logic          was_en = 1'b0;
    int            errors = 0;
    int            checks = 0;
    int            cyc = 0;

    seg_counter #(.CNT_W(CW), .LO_W(LW), .SEG_W(SW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .target    (target),
        .count     (count),
        .at_target (at_target)
    );

    always #2.5 clk = ~clk;

    // arithmetic model of the requirements
    always @(posedge clk) begin
        was_rst <= rst;
        was_en  <= en;
        if (rst) begin
            ref_cnt  <= '0;
            ref_flag <= 1'b0;
        end else begin
            ref_cnt  <= en ? ref_cnt + 1'b1 : ref_cnt;
            ref_flag <= ((en ? ref_cnt + 1'b1 : ref_cnt) == target);
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    task automatic sample();
        string ct;
        string ft;
        if (was_rst) ct = "R1 count after reset";
        else if (!was_en) ct = "R5 count held";
        else if (ref_cnt == '0) ct = "R4 wrap to zero";
        else if (ref_cnt[LW-1:0] == '0) ct = "R3 segment roll";
        else ct = "R2 count step";
        if (was_rst) ft = "R1 flag after reset";
        else if (target == '0 || target == 1 || target == MAXV) ft = "R7 edge target flag";
        else ft = "R6 target flag";
        check(count == ref_cnt, ct, int'(count), int'(ref_cnt));
        check(at_target == ref_flag, ft, int'(at_target), int'(ref_flag));
    endtask

    task automatic run_target(input logic [CW-1:0] tg);
        @(negedge clk);
        rst = 1'b1;
        en = 1'b0;
        target = tg;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            sample();
        end
        rst = 1'b0;
        // idle first: the flag must settle on a count that is not moving
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            sample();
        end
        for (int i = 0; i < 1300; i++) begin
            @(negedge clk);
            sample();
            en = ((i % 9) != 4) && !(i >= 600 && i < 606);
        end
        en = 1'b0;
    endtask

    initial begin
        @(posedge clk);
        @(negedge clk);
        sample();
        run_target(CW'(5));
        run_target('0);
        run_target(CW'(1));
        run_target(MAXV);
        run_target(CW'(31));
        run_target(CW'(530));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule